// File: doc/BRIEF.md
# Split-Read 64-bit Cycle Counter

This block keeps a free-running 64-bit cycle counter and exposes it through a 32-bit register port. Software cannot fetch all 64 bits in one access. It reads the low word, then the high word, then the control register. A tracking state machine inside the block watches that sequence. Bit 31 of the control read tells software whether the two halves it just fetched belong to the same instant. If they do not, software repeats the sequence.

Two events spoil a pair. The first is an exception or interrupt entry, signalled by a one-cycle pulse on `exc_entry`, that arrives between the low read and the high read. The second is a carry out of the low word, which changes the high word while the sequence is in progress.

The counter is enabled through bit 0 of the control register. Software never loads it. The `RESET_VALUE` parameter only sets its value after reset.

The tracker has three states:
- `TRK_IDLE`: no sequence is in progress.
- `TRK_LOW_SEEN`: the low word has been read. The error flag is collecting events.
- `TRK_PAIR_DONE`: the high word has been read. The result waits for a control read.

Its transitions are:
- **start**: a low read from any state moves to `TRK_LOW_SEEN`. It restarts the error flag from the carry of that same cycle.
- **finish**: a high read in `TRK_LOW_SEEN` moves to `TRK_PAIR_DONE`.
- **abort**: a control read in `TRK_LOW_SEEN` returns to `TRK_IDLE`.
- **report**: a control read in `TRK_PAIR_DONE` returns to `TRK_IDLE`.
- **orphan**: a high read in `TRK_PAIR_DONE` or in `TRK_IDLE` leaves the tracker in `TRK_IDLE`.

Top module: `split_read_counter`

## Requirements
- R1: After reset the count equals `RESET_VALUE` (default 0), the counter is disabled, and a control read returns 0.
- R2: A write to the control address (0x103) loads the enable from bit 0 of the write data. While enabled, the count rises by exactly one per clock.
- R3: While disabled the count holds its value. Writes to the low (0x104) or high (0x105) address never change the count.
- R4: A read of 0x104 returns count bits 31:0 and a read of 0x105 returns count bits 63:32. Both show the value held during the read cycle.
- R5: The sequence low read, high read, control read, with no spoiling event in between, returns control bit 31 = 1.
- R6: An `exc_entry` pulse in any cycle strictly after the low read and strictly before the high read makes control bit 31 read 0. A pulse in the low-read cycle or the high-read cycle has no effect.
- R7: If the high word increments after the low read and before the high read, the following control read returns bit 31 = 0.
- R8: Control bit 31 reads 0 in three cases: after a high read with no preceding low read, on a control read made before the high read, and on a second control read after a report. A new low read always restarts the sequence.
- R9: A control read returns the enable in bit 0 and zeros in bits 30:1. `bus_rdata` is 0 when no read is made or when the address is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (12) | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the read cycle |
| exc_entry | input | 1 | One-cycle pulse on interrupt or exception entry |

## Verification
Clean low/high/control sequences are expected to report a valid pair. The same sequences with an entry pulse placed inside the window, or on either of its edge cycles, separate the spoiling cycles from the harmless ones. A directed pair that straddles the low-word carry, with the counter started close to the wrap, shows that a high-word change is detected. Orphan high reads, early control reads and repeated control reads cover the malformed sequences. A long seeded random mix of reads, writes and pulses is compared read by read against a model in the bench.

// File: rtl/splitrd_pkg.sv
package splitrd_pkg;

    typedef enum logic [1:0] {
        TRK_IDLE      = 2'd0,
        TRK_LOW_SEEN  = 2'd1,
        TRK_PAIR_DONE = 2'd2
    } trk_state_e;

    localparam int STATUS_BIT = 31;
    localparam int ENABLE_BIT = 0;

endpackage

// File: rtl/splitrd_counter.sv
module splitrd_counter #(
    parameter int              CNT_W       = 64,
    parameter int              LO_W        = 32,
    parameter logic [CNT_W-1:0] RESET_VALUE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] cnt,
    output logic             carry_lo
);

    localparam logic [LO_W-1:0] LO_ALL_ONES = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= RESET_VALUE;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Carry into the upper word happens at the coming edge.
    assign carry_lo = en && (cnt[LO_W-1:0] == LO_ALL_ONES);

    p_step_when_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> cnt == $past(cnt) + 1'b1);

    p_hold_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt));

endmodule

// File: rtl/splitrd_tracker.sv
module splitrd_tracker
    import splitrd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_lo,
    input  logic rd_hi,
    input  logic rd_ctrl,
    input  logic exc_entry,
    input  logic carry_lo,
    output logic pair_ok
);

    trk_state_e state, state_n;
    logic       err, err_n;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TRK_IDLE;
            err   <= 1'b0;
        end else begin
            state <= state_n;
            err   <= err_n;
        end
    end

    // Transitions.
    always_comb begin
        state_n = state;
        err_n   = err;
        unique case (state)
            TRK_IDLE: begin
                if (rd_lo) begin
                    state_n = TRK_LOW_SEEN;   // start
                    err_n   = carry_lo;
                end
            end
            TRK_LOW_SEEN: begin
                if (rd_lo) begin
                    state_n = TRK_LOW_SEEN;   // start again
                    err_n   = carry_lo;
                end else if (rd_hi) begin
                    state_n = TRK_PAIR_DONE;  // finish
                end else if (rd_ctrl) begin
                    state_n = TRK_IDLE;       // abort
                end else begin
                    err_n = err | carry_lo | exc_entry;
                end
            end
            TRK_PAIR_DONE: begin
                if (rd_lo) begin
                    state_n = TRK_LOW_SEEN;
                    err_n   = carry_lo;
                end else if (rd_hi || rd_ctrl) begin
                    state_n = TRK_IDLE;       // orphan or report
                end
            end
            default: begin
                state_n = TRK_IDLE;
                err_n   = 1'b0;
            end
        endcase
    end

    // Output.
    always_comb begin
        pair_ok = (state == TRK_PAIR_DONE) && !err;
    end

    p_exc_spoils_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRK_LOW_SEEN && exc_entry && !rd_lo && !rd_hi && !rd_ctrl) |=> err);

    p_carry_spoils_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRK_LOW_SEEN && carry_lo && !rd_lo && !rd_hi && !rd_ctrl) |=> err);

    p_done_from_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == TRK_PAIR_DONE) |-> $past(state == TRK_LOW_SEEN && rd_hi));

    p_ctrl_ends_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !rd_lo) |=> state == TRK_IDLE);

    p_orphan_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi && state != TRK_LOW_SEEN) |=> state == TRK_IDLE);

endmodule

// File: rtl/splitrd_regs.sv
module splitrd_regs
    import splitrd_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter int              REG_W     = 32,
    parameter int              CNT_W     = 64,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h103,
    parameter logic [ADDR_W-1:0] LO_ADDR   = 12'h104,
    parameter logic [ADDR_W-1:0] HI_ADDR   = 12'h105
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              pair_ok,
    output logic              en,
    output logic              rd_lo,
    output logic              rd_hi,
    output logic              rd_ctrl,
    output logic [REG_W-1:0]  bus_rdata
);

    localparam int N_WORDS = CNT_W / REG_W;

    logic [REG_W-1:0] word [N_WORDS];

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        assign word[g] = cnt[g*REG_W +: REG_W];
    end

    assign rd_lo   = bus_rd && (bus_addr == LO_ADDR);
    assign rd_hi   = bus_rd && (bus_addr == HI_ADDR);
    assign rd_ctrl = bus_rd && (bus_addr == CTRL_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0;
        end else if (bus_wr && bus_addr == CTRL_ADDR) begin
            en <= bus_wdata[ENABLE_BIT];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_lo) begin
            bus_rdata = word[0];
        end else if (rd_hi) begin
            bus_rdata = word[N_WORDS-1];
        end else if (rd_ctrl) begin
            bus_rdata[ENABLE_BIT] = en;
            bus_rdata[STATUS_BIT] = pair_ok;
        end
    end

endmodule

// File: rtl/split_read_counter.sv
module split_read_counter #(
    parameter int              ADDR_W      = 12,
    parameter logic [63:0]     RESET_VALUE = 64'd0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 12'h103,
    parameter logic [ADDR_W-1:0] LO_ADDR     = 12'h104,
    parameter logic [ADDR_W-1:0] HI_ADDR     = 12'h105
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              exc_entry
);

    localparam int REG_W = 32;
    localparam int CNT_W = 64;

    logic [CNT_W-1:0] cnt;
    logic             carry_lo;
    logic             en;
    logic             rd_lo, rd_hi, rd_ctrl;
    logic             pair_ok;

    splitrd_counter #(
        .CNT_W      (CNT_W),
        .LO_W       (REG_W),
        .RESET_VALUE(RESET_VALUE)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .cnt     (cnt),
        .carry_lo(carry_lo)
    );

    splitrd_tracker u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_lo    (rd_lo),
        .rd_hi    (rd_hi),
        .rd_ctrl  (rd_ctrl),
        .exc_entry(exc_entry),
        .carry_lo (carry_lo),
        .pair_ok  (pair_ok)
    );

    splitrd_regs #(
        .ADDR_W   (ADDR_W),
        .REG_W    (REG_W),
        .CNT_W    (CNT_W),
        .CTRL_ADDR(CTRL_ADDR),
        .LO_ADDR  (LO_ADDR),
        .HI_ADDR  (HI_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .cnt      (cnt),
        .pair_ok  (pair_ok),
        .en       (en),
        .rd_lo    (rd_lo),
        .rd_hi    (rd_hi),
        .rd_ctrl  (rd_ctrl),
        .bus_rdata(bus_rdata)
    );

    p_quiet_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == 32'd0);

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == CTRL_ADDR) |-> bus_rdata[30:1] == 30'd0);

endmodule

// File: tb/test_split_read_counter.sv
module test_split_read_counter;

    localparam logic [11:0] A_CTRL = 12'h103;
    localparam logic [11:0] A_LO   = 12'h104;
    localparam logic [11:0] A_HI   = 12'h105;
    localparam logic [11:0] A_BAD  = 12'h0A7;
    localparam logic [63:0] RST_V  = 64'h0000_0001_FFFF_FF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        exc_entry = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    split_read_counter #(.RESET_VALUE(RST_V)) i_split_read_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .exc_entry(exc_entry)
    );

    // Reference model built from the requirements.
    logic [63:0] m_cnt;
    logic        m_en, m_seen, m_done, m_err;

    always @(posedge clk) begin
        logic carry;
        if (!rst_n) begin
            m_cnt = RST_V; m_en = 0; m_seen = 0; m_done = 0; m_err = 0;
        end else begin
            carry = m_en && (m_cnt[31:0] == 32'hFFFF_FFFF);
            if (bus_rd && bus_addr == A_LO) begin
                m_seen = 1; m_done = 0; m_err = carry;
            end else if (bus_rd && bus_addr == A_HI) begin
                m_done = m_seen; m_seen = 0;
            end else if (bus_rd && bus_addr == A_CTRL) begin
                m_seen = 0; m_done = 0;
            end else if (m_seen) begin
                m_err = m_err | carry | exc_entry;
            end
            if (m_en) m_cnt = m_cnt + 64'd1;
            if (bus_wr && bus_addr == A_CTRL) m_en = bus_wdata[0];
        end
    end

    function automatic logic [31:0] exp_rdata(input logic rd, input logic [11:0] a);
        if (!rd) return 32'd0;
        if (a == A_LO) return m_cnt[31:0];
        if (a == A_HI) return m_cnt[63:32];
        if (a == A_CTRL) return {m_done && !m_err, 30'd0, m_en};
        return 32'd0;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle; drives at the falling edge, samples before the rising edge.
    task automatic op(input logic rd, input logic wr, input logic [11:0] a,
                      input logic [31:0] wd, input logic exc, input string req);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; exc_entry = exc;
        #2;
        check(bus_rdata, exp_rdata(rd, a), req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(0, 0, A_BAD, 32'd0, 0, "R9");
    endtask

    task automatic rd(input logic [11:0] a, input string req);
        op(1, 0, a, 32'd0, 0, req);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lo_a;
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        rd(A_CTRL, "R1");
        rd(A_LO, "R1");
        check(bus_rdata, RST_V[31:0], "R1 low");
        rd(A_HI, "R1");
        check(bus_rdata, RST_V[63:32], "R1 high");

        // R3: disabled counter holds, writes to count addresses ignored
        idle(3);
        op(0, 1, A_LO, 32'h1234_5678, 0, "R3");
        op(0, 1, A_HI, 32'hCAFE_0000, 0, "R3");
        rd(A_LO, "R3");
        check(bus_rdata, RST_V[31:0], "R3 hold low");
        rd(A_HI, "R3");
        check(bus_rdata, RST_V[63:32], "R3 hold high");

        // R2: enable and stepping
        op(0, 1, A_CTRL, 32'h0000_0001, 0, "R2");
        rd(A_LO, "R2");
        lo_a = bus_rdata;
        idle(4);
        rd(A_LO, "R2");
        check(bus_rdata, lo_a + 32'd5, "R2 step");
        rd(A_CTRL, "R2 R9");

        // R5: clean sequence
        rd(A_LO, "R4"); idle(2); rd(A_HI, "R4"); rd(A_CTRL, "R5");
        check(bus_rdata[31], 1'b1, "R5 valid");

        // R6: pulse inside window spoils, pulses on edge cycles do not
        rd(A_LO, "R4"); op(0, 0, A_BAD, 0, 1, "R6"); rd(A_HI, "R4"); rd(A_CTRL, "R6");
        check(bus_rdata[31], 1'b0, "R6 spoiled");
        op(1, 0, A_LO, 0, 1, "R6"); rd(A_HI, "R4"); rd(A_CTRL, "R6");
        check(bus_rdata[31], 1'b1, "R6 pulse on low cycle");
        rd(A_LO, "R4"); op(1, 0, A_HI, 0, 1, "R6"); rd(A_CTRL, "R6");
        check(bus_rdata[31], 1'b1, "R6 pulse on high cycle");

        // R8: malformed sequences
        rd(A_HI, "R8"); rd(A_CTRL, "R8");
        check(bus_rdata[31], 1'b0, "R8 orphan high");
        rd(A_LO, "R8"); rd(A_CTRL, "R8");
        check(bus_rdata[31], 1'b0, "R8 early control");
        rd(A_LO, "R8"); rd(A_HI, "R8"); rd(A_CTRL, "R8"); rd(A_CTRL, "R8");
        check(bus_rdata[31], 1'b0, "R8 repeated control");
        rd(A_LO, "R8"); op(0, 0, A_BAD, 0, 1, "R8"); rd(A_LO, "R8"); rd(A_HI, "R8"); rd(A_CTRL, "R8");
        check(bus_rdata[31], 1'b1, "R8 restart");
        op(1, 0, A_BAD, 0, 0, "R9");

        // R7: carry into the high word between the reads
        while (m_cnt[63:32] == 32'd1 && m_cnt[31:0] < 32'hFFFF_FFF8) idle(1);
        rd(A_LO, "R7");
        idle(12);
        rd(A_HI, "R7");
        check(bus_rdata, 32'd2, "R7 high moved");
        rd(A_CTRL, "R7");
        check(bus_rdata[31], 1'b0, "R7 spoiled");

        // Random mix against the model
        for (int i = 0; i < 4000; i++) begin
            int unsigned k = $urandom_range(0, 11);
            logic exc = ($urandom_range(0, 7) == 0);
            case (k)
                0, 1, 2: op(1, 0, A_LO, 0, exc, "R4 R6");
                3, 4, 5: op(1, 0, A_HI, 0, exc, "R4 R7");
                6, 7:    op(1, 0, A_CTRL, 0, exc, "R5 R8");
                8:       op(1, 0, A_BAD, 0, exc, "R9");
                9:       op(0, 1, A_CTRL, {$urandom, 1'b0} | (($urandom_range(0, 5) != 0) ? 33'd1 : 33'd0), exc, "R2");
                10:      op(0, 1, A_LO, $urandom, exc, "R3");
                default: op(0, 0, A_BAD, 0, exc, "R9");
            endcase
        end

        // R3: disable and hold
        op(0, 1, A_CTRL, 32'd0, 0, "R3");
        rd(A_LO, "R3");
        lo_a = bus_rdata;
        idle(6);
        rd(A_LO, "R3");
        check(bus_rdata, lo_a, "R3 hold after disable");
        rd(A_CTRL, "R9");
        check(bus_rdata[0], 1'b0, "R9 enable readback");
        idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule